// File: doc/BRIEF.md
# Level-Triggered DMA Request Channel

A single DMA channel for single-address transfers. A peripheral asks for service by holding an active-low request pin low. Each time the channel samples that pin low while it is open to requests, it latches the request and runs a short sequence. First comes a clearance period, in which the latched request is dropped and activation begins. Then the channel raises a bus request and waits for a grant. Last comes one memory bus cycle, in which the peripheral is selected by an acknowledge strobe rather than by an address. The channel stays closed to new requests from the moment a request is latched until that bus cycle has ended.

Software programs the channel through a single-cycle write port that carries an enable, a start memory address and a transfer count. Every completed cycle moves the address forward by one transfer unit and lowers the count by one. When the count reaches zero, the channel disables itself, sets a done flag and stops sampling the pin. The bus cycle direction is fixed by a parameter: either the peripheral writes to memory or memory is read out to the peripheral.

Top module: `dma_lvl_chan`

## Requirements
- R1: While reset is low and directly after it, bus_req_o, dack_o, mem_rd_o, mem_wr_o and done_o are 0 and mem_addr_o is 0.
- R2: The pin is not sampled in the cycle of a configuration write. The first sample is taken on the first rising edge after the write that enables the channel.
- R3: While the channel is enabled and idle, a low level on req_ni at a rising edge latches a request. bus_req_o rises CLR_CYC+1 edges after that sampling edge.
- R4: The data cycle (dack_o high) starts CLR_CYC+2 edges after the sampling edge when the grant is already present, and never earlier.
- R5: dack_o is high for exactly one cycle per transfer. In that cycle mem_addr_o carries the transfer address and exactly one strobe is high: mem_wr_o when TO_MEM=1, mem_rd_o otherwise. bus_req_o is high during the data cycle and falls on the edge that ends it.
- R6: No request is accepted between the latching edge and the end of the data cycle it caused, so a pin held low gives one transfer per full sequence.
- R7: Sampling resumes on the second rising edge after the data cycle begins. With the pin held low and a grant delay of G cycles, transfers repeat every CLR_CYC+4+G cycles.
- R8: The data cycle starts only on an edge at which bus_gnt_i is high while bus_req_o is high. Until then bus_req_o stays high and dack_o stays low.
- R9: The address of transfer i is the start address plus i*UNIT_BYTES, modulo 2^ADDR_W.
- R10: After exactly the programmed number of transfers, done_o is 1, the channel is disabled, and bus_req_o stays 0 even with the pin held low.
- R11: A write with enable=1 and count=0 sets done_o on the next edge and starts no transfer. A write with enable=0 clears done_o and disables sampling.
- R12: A configuration write while a request is latched or a sequence is in progress has no effect. The running address, count and completion are unchanged.
- R13: With req_ni held high, an enabled channel never raises bus_req_o. A single one-cycle low pulse gives exactly one transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_ni | input | 1 | Peripheral transfer request, active low, level sensitive |
| cfg_we_i | input | 1 | Configuration write strobe (one cycle) |
| cfg_en_i | input | 1 | Enable value written with cfg_we_i |
| cfg_addr_i | input | ADDR_W | Start memory address written with cfg_we_i |
| cfg_cnt_i | input | CNT_W | Transfer count written with cfg_we_i |
| bus_gnt_i | input | 1 | Bus grant from the arbiter |
| bus_req_o | output | 1 | Bus request to the arbiter |
| mem_addr_o | output | ADDR_W | Memory address, valid during the data cycle, 0 otherwise |
| mem_rd_o | output | 1 | Memory read strobe during the data cycle (TO_MEM=0) |
| mem_wr_o | output | 1 | Memory write strobe during the data cycle (TO_MEM=1) |
| dack_o | output | 1 | Peripheral acknowledge, high for the data cycle |
| done_o | output | 1 | Programmed count exhausted |

## Verification
The bench builds the channel with ADDR_W=8, CNT_W=4, UNIT_BYTES=2, CLR_CYC=1 and TO_MEM=1. With these values it can sweep every count from 0 to 15 against grant delays of 0 to 3 cycles, with the request pin held low. Each transfer's edge is predicted from the write edge and the repeat period, and each address from the start address and step. The 8-bit address makes wrap past the top of the space common across the sweep. Separate cases cover a write issued while a sequence is running, an idle pin, a single one-cycle pulse, and disabling after completion.

// File: rtl/dma_lvl_pkg.sv
package dma_lvl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CLR  = 2'd1,
    ST_ARB  = 2'd2,
    ST_XFER = 2'd3
  } xfer_st_e;
endpackage

// File: rtl/dma_req_latch.sv
module dma_req_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_ni,
  input  logic accept_i,
  input  logic clear_i,
  output logic held_o
);
  logic held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  held_q <= 1'b0;
    else if (clear_i)             held_q <= 1'b0;
    else if (accept_i && !req_ni) held_q <= 1'b1;
  end

  assign held_o = held_q;
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dma_lvl_pkg::*;
#(
  parameter int CLR_CYC = 1
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     held_i,
  input  logic     gnt_i,
  output xfer_st_e st_o,
  output logic     start_o,
  output logic     xfer_end_o
);
  localparam int CW = (CLR_CYC > 1) ? $clog2(CLR_CYC) : 1;
  localparam logic [CW-1:0] CLR_LAST = CW'(CLR_CYC - 1);

  xfer_st_e st_q, st_d;
  logic [CW-1:0] clr_q, clr_d;

  always_comb begin
    st_d       = st_q;
    clr_d      = clr_q;
    start_o    = 1'b0;
    xfer_end_o = 1'b0;
    unique case (st_q)
      ST_IDLE: if (held_i) begin
        st_d    = ST_CLR;
        clr_d   = '0;
        start_o = 1'b1;
      end
      ST_CLR: begin
        if (clr_q == CLR_LAST) st_d = ST_ARB;
        else                   clr_d = clr_q + 1'b1;
      end
      ST_ARB: if (gnt_i) st_d = ST_XFER;
      ST_XFER: begin
        st_d       = ST_IDLE;
        xfer_end_o = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      clr_q <= '0;
    end else begin
      st_q  <= st_d;
      clr_q <= clr_d;
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs #(
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 16,
  parameter int UNIT_BYTES = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              step_i,
  output logic              en_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(UNIT_BYTES);
  localparam logic [CNT_W-1:0]  ONE  = CNT_W'(1);

  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              en_q, done_q;
  logic              cnt_zero_in;

  assign cnt_zero_in = (cnt_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
      en_q   <= 1'b0;
      done_q <= 1'b0;
    end else if (wr_i) begin
      addr_q <= addr_i;
      cnt_q  <= cnt_i;
      en_q   <= en_i && !cnt_zero_in;
      done_q <= en_i && cnt_zero_in;
    end else if (step_i) begin
      addr_q <= addr_q + STEP;
      cnt_q  <= cnt_q - ONE;
      if (cnt_q == ONE) begin
        en_q   <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign en_o   = en_q;
  assign done_o = done_q;
  assign addr_o = addr_q;
endmodule

// File: rtl/dma_lvl_chan.sv
module dma_lvl_chan
  import dma_lvl_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 16,
  parameter int UNIT_BYTES = 1,
  parameter int CLR_CYC    = 1,
  parameter bit TO_MEM     = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_en_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [CNT_W-1:0]  cfg_cnt_i,
  input  logic              bus_gnt_i,
  output logic              bus_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              dack_o,
  output logic              done_o
);
  xfer_st_e          st;
  logic              req_held, start, xfer_end;
  logic              chan_en, quiet, accept, cfg_wr;
  logic [ADDR_W-1:0] cur_addr;
  logic              in_xfer;

  // writes land only when no request is pending or in flight
  assign quiet   = (st == ST_IDLE) && !req_held;
  assign cfg_wr  = cfg_we_i && quiet;
  assign accept  = chan_en && quiet && !cfg_we_i;
  assign in_xfer = (st == ST_XFER);

  dma_req_latch u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_ni   (req_ni),
    .accept_i (accept),
    .clear_i  (start),
    .held_o   (req_held)
  );

  dma_xfer_fsm #(.CLR_CYC(CLR_CYC)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .held_i     (req_held),
    .gnt_i      (bus_gnt_i),
    .st_o       (st),
    .start_o    (start),
    .xfer_end_o (xfer_end)
  );

  dma_cfg_regs #(
    .ADDR_W     (ADDR_W),
    .CNT_W      (CNT_W),
    .UNIT_BYTES (UNIT_BYTES)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (cfg_wr),
    .en_i   (cfg_en_i),
    .addr_i (cfg_addr_i),
    .cnt_i  (cfg_cnt_i),
    .step_i (xfer_end),
    .en_o   (chan_en),
    .done_o (done_o),
    .addr_o (cur_addr)
  );

  assign bus_req_o  = (st == ST_ARB) || in_xfer;
  assign dack_o     = in_xfer;
  assign mem_addr_o = in_xfer ? cur_addr : '0;

  generate
    if (TO_MEM) begin : g_to_mem
      assign mem_wr_o = in_xfer;
      assign mem_rd_o = 1'b0;
    end else begin : g_from_mem
      assign mem_wr_o = 1'b0;
      assign mem_rd_o = in_xfer;
    end
  endgenerate
endmodule

// File: rtl/dma_lvl_chan_chk.sv
module dma_lvl_chan_chk #(
  parameter int CLR_CYC = 1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic dack_o,
  input logic bus_req_o,
  input logic bus_gnt_i,
  input logic done_o,
  input logic mem_rd_o,
  input logic mem_wr_o,
  input logic req_held
);
  localparam int GAP = CLR_CYC + 2;
  localparam int GW  = $clog2(GAP + 2) + 1;
  localparam logic [GW-1:0] GSAT = GW'(GAP + 1);

  logic          held_d;
  logic [GW-1:0] gap_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_d  <= 1'b0;
      gap_cnt <= GSAT;
    end else begin
      held_d <= req_held;
      if (req_held && !held_d)  gap_cnt <= GW'(1);
      else if (gap_cnt != GSAT) gap_cnt <= gap_cnt + 1'b1;
    end
  end

  a_r4_min_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dack_o) |-> gap_cnt >= GW'(GAP));

  a_r5_dack_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dack_o |=> !dack_o);

  a_r5_dack_owns_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dack_o |-> bus_req_o && (mem_rd_o ^ mem_wr_o));

  a_r8_grant_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dack_o) |-> $past(bus_gnt_i) && $past(bus_req_o));

  a_r6_closed_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_held |-> !bus_req_o);

  a_r10_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !bus_req_o);
endmodule

bind dma_lvl_chan dma_lvl_chan_chk #(.CLR_CYC(CLR_CYC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .dack_o    (dack_o),
  .bus_req_o (bus_req_o),
  .bus_gnt_i (bus_gnt_i),
  .done_o    (done_o),
  .mem_rd_o  (mem_rd_o),
  .mem_wr_o  (mem_wr_o),
  .req_held  (req_held)
);

// File: tb/dma_lvl_chan_tb.sv
`timescale 1ns/1ps
module dma_lvl_chan_tb;
  localparam int ADDR_W = 8;
  localparam int CNT_W  = 4;
  localparam int UNIT   = 2;
  localparam int CLR    = 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_ni = 1'b1, cfg_we = 1'b0, cfg_en = 1'b0, gnt = 1'b0;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic [CNT_W-1:0]  cfg_cnt = '0;
  logic bus_req, mem_rd, mem_wr, dack, done;
  logic [ADDR_W-1:0] mem_addr;

  int tests = 0, fails = 0;
  int edge_n = 0;
  int gd = 0, gcnt = 0;
  int exp_first = 0, exp_period = 1, exp_n = 0, seen = 0;
  logic [ADDR_W-1:0] exp_base = '0;

  always #5 clk = ~clk;

  dma_lvl_chan #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .UNIT_BYTES(UNIT), .CLR_CYC(CLR), .TO_MEM(1'b1)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_ni(req_ni), .cfg_we_i(cfg_we),
    .cfg_en_i(cfg_en), .cfg_addr_i(cfg_addr), .cfg_cnt_i(cfg_cnt),
    .bus_gnt_i(gnt), .bus_req_o(bus_req), .mem_addr_o(mem_addr),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .dack_o(dack), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) edge_n <= edge_n + 1;

  // arbiter model: grant gd negedges after request seen
  always @(negedge clk) begin
    if (!bus_req) begin
      gnt  = 1'b0;
      gcnt = 0;
    end else if (!gnt) begin
      if (gcnt == gd) gnt = 1'b1;
      else gcnt++;
    end
  end

  // transfer monitor: timing (R4,R7,R8), address (R9), strobes (R5), count bound (R6,R10,R13)
  always @(negedge clk) begin
    if (rst_ni && dack) begin
      logic [ADDR_W-1:0] ea;
      ea = exp_base + ADDR_W'(seen * UNIT);
      check(seen < exp_n, "R10 extra transfer", seen + 1, exp_n);
      check(edge_n == exp_first + seen * exp_period, "R4/R7/R8 transfer edge",
            edge_n, exp_first + seen * exp_period);
      check(mem_addr == ea, "R9 address", mem_addr, ea);
      check(mem_wr && !mem_rd && bus_req, "R5 strobes", {mem_wr, mem_rd, bus_req}, 3'b101);
      seen++;
    end
  end

  task automatic write_cfg(input bit en, input logic [ADDR_W-1:0] a, input logic [CNT_W-1:0] c);
    @(negedge clk);
    cfg_we = 1'b1; cfg_en = en; cfg_addr = a; cfg_cnt = c;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_case(input int c, input int g, input logic [ADDR_W-1:0] base, input bit busy_wr);
    int w;
    gd = g;
    @(negedge clk);
    w = edge_n + 1;
    seen = 0; exp_n = c; exp_base = base;
    exp_first = w + 3 + CLR + g;
    exp_period = 4 + CLR + g;
    cfg_we = 1'b1; cfg_en = 1'b1; cfg_addr = base; cfg_cnt = CNT_W'(c);
    req_ni = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0;
    if (c == 0) check(done == 1'b1, "R11 zero count done", done, 1);
    else check(!bus_req, "R2 no sample on write edge", bus_req, 0);
    if (busy_wr && c > 0) begin
      while (!bus_req) @(negedge clk);
      cfg_we = 1'b1; cfg_en = 1'b1; cfg_addr = 8'h99; cfg_cnt = 4'd9;
      @(negedge clk);
      cfg_we = 1'b0;
    end
    repeat (c * exp_period + 12) @(negedge clk);
    check(seen == c, busy_wr ? "R12 busy write ignored" : "R10 transfer total", seen, c);
    check(done == 1'b1, "R10 done set", done, 1);
    check(!bus_req, "R10 idle after done", bus_req, 0);
    req_ni = 1'b1;
    write_cfg(1'b0, '0, '0);
    check(done == 1'b0, "R11 disable clears done", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({bus_req, dack, mem_rd, mem_wr, done, mem_addr} == '0, "R1 in reset",
          {bus_req, dack, mem_rd, mem_wr, done, mem_addr}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check({bus_req, dack, mem_rd, mem_wr, done, mem_addr} == '0, "R1 after reset",
          {bus_req, dack, mem_rd, mem_wr, done, mem_addr}, 0);

    // sweep count x grant delay with pin held low (R3, R4, R6, R7, R8, R9, R10)
    for (int c = 0; c < 16; c++)
      for (int g = 0; g < 4; g++)
        run_case(c, g, ADDR_W'(c * 37 + g * 91 + 200), 1'b0);

    // R12: write while a sequence is in flight
    run_case(3, 3, 8'h40, 1'b1);

    // R13: idle pin never requests; single pulse gives one transfer
    gd = 0; seen = 0; exp_n = 0; exp_base = 8'hFE;
    write_cfg(1'b1, 8'hFE, 4'd5);
    repeat (40) begin
      @(negedge clk);
      check(!bus_req, "R13 idle pin", bus_req, 0);
    end
    req_ni = 1'b0;
    exp_n = 1;
    exp_first = edge_n + 1 + CLR + 2;
    exp_period = 4 + CLR;
    // R3: request rises CLR+1 edges after sampling
    @(negedge clk);
    req_ni = 1'b1;
    repeat (CLR + 1) @(negedge clk);
    check(bus_req == 1'b1, "R3 request timing", bus_req, 1);
    repeat (30) @(negedge clk);
    check(seen == 1, "R13 one pulse one transfer", seen, 1);
    check(!done, "R13 count not exhausted", done, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (edge_n > 150000);
    fails++; tests++;
    $display("FAIL watchdog actual=%0d expected=%0d", edge_n, 150000);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule